// File: doc/BRIEF.md
# I2C Receive Run Sequencer

This block performs the data phase of an I2C master read. Addressing, START and STOP are already done by other logic. Software writes one control byte that carries a byte count and a flag that asks for a not-acknowledge on the final byte. The sequencer then generates SCL itself and shifts that many bytes in from SDA. It acknowledges each byte by pulling SDA low in the ninth clock, and pushes every completed byte into a receive FIFO. When the last byte has landed, it raises a read-complete status bit.

Software then pops the bytes out one at a time in arrival order. A FIFO status byte tells it whether anything is left. A transfer longer than the FIFO is issued as several runs, and the flag is set only on the final run. Earlier runs therefore end with an acknowledge, and the slave keeps sending.

Top module: `i2c_rx_seq`

## Requirements
- R1: After reset SCL is high, SDA is released, the FIFO-empty flag (fifo_stat bit 2) is 1 and the read-complete flag (int_stat bit 4) is 0.
- R2: A control write takes the byte count from wr_data bits 6..0 and the NAK-last flag from wr_data bit 7; a count above DEPTH is treated as DEPTH.
- R3: Each bit holds SCL low for HALF_CYC clock cycles and then high for HALF_CYC cycles. A run of N bytes gives exactly 9*N rising SCL edges. Data is captured MSB first at the rising edge, and SDA is never driven during the eight data bits.
- R4: In the ninth (acknowledge) clock of each byte the sequencer pulls SDA low, with one exception: on the last byte of a run whose NAK-last flag is 1, it leaves SDA released.
- R5: Every received byte enters the FIFO. rd_data shows the oldest byte, and a pop advances to the next one in arrival order. A pop while the FIFO is empty has no effect.
- R6: fifo_stat bit 2 is 1 exactly when the FIFO holds no bytes.
- R7: int_stat bit 4 becomes 1 on the clock edge that stores the last byte of a run. A status write with wr_data bit 4 = 1 clears it, and a status write with bit 4 = 0 leaves it unchanged.
- R8: A control write with count 0 produces no SCL edge and sets int_stat bit 4 on the same clock edge.
- R9: A control write while a run is in progress is ignored; the run finishes with its original count.
- R10: After a run SCL stays low and SDA stays released until the next accepted control write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Write strobe for the control byte (count and NAK-last flag) |
| isr_wr | input | 1 | Write strobe for the status byte (write-1-to-clear) |
| wr_data | input | 8 | Data for either write strobe |
| pop | input | 1 | Removes the oldest byte from the FIFO |
| rd_data | output | 8 | Oldest byte held in the FIFO |
| int_stat | output | 8 | Status byte, bit 4 = read complete |
| fifo_stat | output | 8 | FIFO status byte, bit 2 = empty |
| scl_o | output | 1 | SCL level driven by the sequencer |
| sda_low_o | output | 1 | 1 pulls SDA low (open-drain drive) |
| sda_i | input | 1 | Sensed SDA level |

## Verification
An off-by-one in the remaining-byte counter shows at the bus within one byte time. The run is then nine SCL edges too long or too short. The NAK also moves to a wrong byte, or goes missing, and the read-complete bit rises a byte early or late.

A slip in the bit counter or the shift register corrupts the bytes popped from the FIFO, and that corruption shows on the first read-out after the run. A FIFO pointer or count error shows at the next pop, or in the empty flag once exactly the expected number of bytes has been drained.

// File: rtl/i2c_rx_pkg.sv
package i2c_rx_pkg;

  localparam int CTL_NAK_BIT    = 7;
  localparam int STAT_DONE_BIT  = 4;
  localparam int FIFO_EMPTY_BIT = 2;
  localparam int CNT_FIELD_W    = 7;

  typedef logic [7:0] byte_t;

  // Count requested by software, limited to what the FIFO can take in one run.
  function automatic logic [CNT_FIELD_W-1:0] clamp_count(
      input logic [CNT_FIELD_W-1:0] raw, input int depth);
    if (int'(raw) > depth) return CNT_FIELD_W'(depth);
    return raw;
  endfunction

  // Pointer advance with wrap for any depth.
  function automatic int unsigned ptr_next(input int unsigned p, input int depth);
    return (p == int'(depth - 1)) ? 0 : p + 1;
  endfunction

endpackage

// File: rtl/rx_byte_fifo.sv
module rx_byte_fifo #(
  parameter int DEPTH = 64,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  import i2c_rx_pkg::*;

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_push) wr_ptr <= AW'(ptr_next(int'(wr_ptr), DEPTH));
      if (do_pop)  rd_ptr <= AW'(ptr_next(int'(rd_ptr), DEPTH));
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  // R5: a pop that takes a byte lowers occupancy by one
  assert_pop_takes_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !empty && !push) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/rx_bit_engine.sv
module rx_bit_engine #(
  parameter int HALF_CYC = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic       more,
  input  logic       ack_en,
  input  logic       sda_i,
  output logic       scl_o,
  output logic       sda_low_o,
  output logic       ack_slot,
  output logic       byte_done,
  output logic [7:0] byte_q
);
  localparam int PW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

  logic          active;
  logic [PW-1:0] ph;
  logic [3:0]    bit_idx;
  logic [7:0]    shreg;
  logic          ph_end;

  assign ph_end    = (ph == PW'(HALF_CYC - 1));
  assign ack_slot  = active && (bit_idx == 4'd8);
  assign sda_low_o = ack_slot && ack_en;
  assign byte_done = ack_slot && scl_o && ph_end;
  assign byte_q    = shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      scl_o   <= 1'b1;
      ph      <= '0;
      bit_idx <= '0;
      shreg   <= '0;
    end else if (!active) begin
      if (go) begin
        active  <= 1'b1;
        scl_o   <= 1'b0;
        ph      <= '0;
        bit_idx <= '0;
      end
    end else if (!ph_end) begin
      ph <= ph + 1'b1;
    end else begin
      ph <= '0;
      if (!scl_o) begin
        scl_o <= 1'b1;
        if (bit_idx != 4'd8) shreg <= {shreg[6:0], sda_i};
      end else begin
        scl_o <= 1'b0;
        if (bit_idx == 4'd8) begin
          bit_idx <= '0;
          if (!more) active <= 1'b0;
        end else begin
          bit_idx <= bit_idx + 1'b1;
        end
      end
    end
  end

  // R10: with no run and no start the bus lines stay put
  assert_bus_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !go) |=> ($stable(scl_o) && !sda_low_o));

  // R3: a byte completes only while SCL is high
  assert_done_on_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> !scl_o);

endmodule

// File: rtl/i2c_rx_seq.sv
module i2c_rx_seq #(
  parameter int DEPTH    = 64,
  parameter int HALF_CYC = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_wr,
  input  logic       isr_wr,
  input  logic [7:0] wr_data,
  input  logic       pop,
  output logic [7:0] rd_data,
  output logic [7:0] int_stat,
  output logic [7:0] fifo_stat,
  output logic       scl_o,
  output logic       sda_low_o,
  input  logic       sda_i
);
  import i2c_rx_pkg::*;

  localparam int CNT_W = CNT_FIELD_W;

  logic             busy, nak_q, done_q;
  logic [CNT_W-1:0] remaining, n_eff;
  logic             start, last_byte, more, ack_en;
  logic             byte_done, ack_slot;
  logic [7:0]       byte_q;
  logic             f_empty, f_full;

  assign n_eff     = clamp_count(wr_data[CNT_W-1:0], DEPTH);
  assign start     = ctl_wr && !busy;
  assign last_byte = (remaining == CNT_W'(1));
  assign more      = busy && !last_byte;
  assign ack_en    = !(nak_q && last_byte);

  rx_bit_engine #(.HALF_CYC(HALF_CYC)) u_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (start && (n_eff != '0)),
    .more      (more),
    .ack_en    (ack_en),
    .sda_i     (sda_i),
    .scl_o     (scl_o),
    .sda_low_o (sda_low_o),
    .ack_slot  (ack_slot),
    .byte_done (byte_done),
    .byte_q    (byte_q)
  );

  rx_byte_fifo #(.DEPTH(DEPTH), .W(8)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (byte_done),
    .din   (byte_q),
    .pop   (pop),
    .dout  (rd_data),
    .empty (f_empty),
    .full  (f_full)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      nak_q     <= 1'b0;
      remaining <= '0;
    end else if (start) begin
      busy      <= (n_eff != '0);
      nak_q     <= wr_data[CTL_NAK_BIT];
      remaining <= n_eff;
    end else if (byte_done) begin
      remaining <= remaining - 1'b1;
      if (last_byte) busy <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else if ((start && (n_eff == '0)) || (byte_done && last_byte)) done_q <= 1'b1;
    else if (isr_wr && wr_data[STAT_DONE_BIT]) done_q <= 1'b0;
  end

  always_comb begin
    int_stat                 = '0;
    int_stat[STAT_DONE_BIT]  = done_q;
    fifo_stat                = '0;
    fifo_stat[FIFO_EMPTY_BIT] = f_empty;
  end

  // R7: storing the last byte raises read-complete
  assert_done_after_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && last_byte) |=> done_q);

  // R8: an empty request completes without a run
  assert_zero_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && (n_eff == '0)) |=> (done_q && !busy));

  // R4: final byte with NAK-last leaves SDA released in its acknowledge clock
  assert_nak_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_slot && nak_q && last_byte) |-> !sda_low_o);

  // R10: SDA is driven only while a run is in progress
  assert_sda_in_run_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sda_low_o |-> busy);

  // R9: a control write during a run leaves the count alone
  assert_busy_write_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && busy && !byte_done) |=> (remaining == $past(remaining)));

  // R5: a completed byte always finds room in the FIFO
  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |-> !f_full);

endmodule

// File: tb/test_i2c_rx_seq.sv
module test_i2c_rx_seq;
  localparam int DEPTH = 64;
  localparam int HALF  = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctl_wr = 1'b0, isr_wr = 1'b0, pop = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data, int_stat, fifo_stat;
  logic       scl_o, sda_low_o, sda_i;

  int total = 0, bad = 0;
  bit finished = 0;
  int cyc = 0;

  // slave model state
  logic slave_bit = 1'b1;
  int   bitpos = 8, k = -1;
  bit   ack_obs [0:1023];
  int   rises = 0, prev_rise = 0, period_bad = 0, drive_bad = 0;
  bit   have_prev = 0;
  int   exp_idx = 0;

  assign sda_i = slave_bit & ~sda_low_o;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  i2c_rx_seq #(.DEPTH(DEPTH), .HALF_CYC(HALF)) i_i2c_rx_seq (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .isr_wr(isr_wr), .wr_data(wr_data),
    .pop(pop), .rd_data(rd_data), .int_stat(int_stat), .fifo_stat(fifo_stat),
    .scl_o(scl_o), .sda_low_o(sda_low_o), .sda_i(sda_i));

  function automatic logic [7:0] pat(input int idx);
    return 8'((idx * 29 + 7) ^ (idx >> 3));
  endfunction

  always @(negedge scl_o) begin
    if (bitpos == 8) begin bitpos = 0; k = k + 1; end
    else bitpos = bitpos + 1;
    slave_bit = (bitpos < 8) ? pat(k)[7 - bitpos] : 1'b1;
  end

  always @(posedge scl_o) begin
    if (rst_n) begin
      rises = rises + 1;
      if (have_prev && (cyc - prev_rise != 2 * HALF)) period_bad = period_bad + 1;
      prev_rise = cyc;
      have_prev = 1;
      if (bitpos == 8) ack_obs[k] = !sda_i;
      else if (sda_low_o) drive_bad = drive_bad + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic status_write(input logic [7:0] v);
    @(negedge clk); wr_data = v; isr_wr = 1'b1;
    @(negedge clk); isr_wr = 1'b0;
  endtask

  task automatic do_run(input int field, input bit nak, input int mid_field);
    int n_eff, guard;
    n_eff = (field > DEPTH) ? DEPTH : field;
    rises = 0; have_prev = 0; period_bad = 0; drive_bad = 0;
    @(negedge clk); wr_data = {nak, 7'(field)}; ctl_wr = 1'b1;
    @(negedge clk); ctl_wr = 1'b0;
    if (n_eff == 0) begin
      chk(int_stat[4] == 1'b1, "R8 done", int_stat[4], 1);
      repeat (12) @(negedge clk);
      chk(rises == 0, "R8 no scl", rises, 0);
    end else begin
      guard = 0;
      while (!int_stat[4] && guard < 20000) begin
        @(negedge clk); guard++;
        if (guard == 40 && mid_field >= 0) begin
          wr_data = 8'(mid_field); ctl_wr = 1'b1;
          @(negedge clk); ctl_wr = 1'b0;
        end
      end
      chk(int_stat[4] == 1'b1, "R7 done raised", int_stat[4], 1);
      chk(rises == 9 * n_eff, "R3 rise count", rises, 9 * n_eff);
      chk(period_bad == 0, "R3 scl period", period_bad, 0);
      chk(drive_bad == 0, "R3 sda free in data", drive_bad, 0);
      for (int i = 0; i < n_eff; i++) begin
        bit exp_ack;
        exp_ack = !(nak && (i == n_eff - 1));
        chk(ack_obs[exp_idx + i] == exp_ack, "R4 ack slot", ack_obs[exp_idx + i], exp_ack);
      end
      repeat (10) @(negedge clk);
      chk(scl_o == 1'b0 && sda_low_o == 1'b0, "R10 bus after run",
          {scl_o, sda_low_o}, 0);
      chk(rises == 9 * n_eff, "R10 no extra edges", rises, 9 * n_eff);
      for (int i = 0; i < n_eff; i++) begin
        chk(fifo_stat[2] == 1'b0, "R6 not empty", fifo_stat[2], 0);
        chk(rd_data == pat(exp_idx + i), "R5 byte order", rd_data, pat(exp_idx + i));
        pop = 1'b1; @(negedge clk); pop = 1'b0;
      end
      chk(fifo_stat[2] == 1'b1, "R6 empty after drain", fifo_stat[2], 1);
      exp_idx += n_eff;
    end
    status_write(8'hEF);
    chk(int_stat[4] == 1'b1, "R7 write0 keeps", int_stat[4], 1);
    status_write(8'h10);
    chk(int_stat[4] == 1'b0, "R7 write1 clears", int_stat[4], 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(scl_o == 1'b1, "R1 scl high", scl_o, 1);
    chk(sda_low_o == 1'b0, "R1 sda free", sda_low_o, 0);
    chk(fifo_stat == 8'h04, "R1 fifo empty", fifo_stat, 4);
    chk(int_stat == 8'h00, "R1 done clear", int_stat, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R5: pop on empty has no effect
    pop = 1'b1; @(negedge clk); pop = 1'b0;
    chk(fifo_stat[2] == 1'b1, "R5 pop on empty", fifo_stat[2], 1);
    // R8: zero count before any run
    do_run(0, 1'b0, -1);
    chk(scl_o == 1'b1, "R8 scl untouched", scl_o, 1);
    // R2 R3 R4: sweep of small counts, both flag values
    for (int n = 1; n <= 8; n++) do_run(n, n[0], -1);
    do_run(16, 1'b1, -1);
    do_run(63, 1'b0, -1);
    do_run(64, 1'b1, -1);
    // R2: count above depth clamps to depth
    do_run(100, 1'b1, -1);
    do_run(0, 1'b1, -1);
    // R9: write during run ignored
    do_run(10, 1'b1, 3);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule